// File: doc/BRIEF.md
# Multi-Warp Issue Picker with Lockout Mask

This block chooses, every cycle, which warp of a SIMT core fetches next. For each warp it holds a program counter, a thread-enable mask, a run bit and a lockout bit. A warp may be chosen when its run bit is set and its lockout bit is clear. Among those warps, the one with the smallest index wins. The chosen warp's index, PC and thread mask go to fetch through a valid/ready pair.

Once a warp is accepted by fetch it is locked out until decode hands it back. A warp that the barrier logic parks loses its run bit until the barrier sets it again. A spawn command starts the other warps at a common entry PC. After reset, only warp 0 runs.

The PC is modelled as stepping by 4 on each accepted issue. Branch targets are handled outside the block.

Top module: `warp_sched`

## Requirements
- R1: After reset the run mask is 1 (warp 0 only), the lockout mask is 0 and the issue counter is 0. Warp 0 has PC RESET_PC and thread mask 1 (thread 0 only). Every other warp has thread mask 0 and PC 0.
- R2: `issue_valid` is high exactly when some warp has its run bit set and its lockout bit clear. `issue_wid` is the lowest such warp index, and `issue_pc`/`issue_tmask` are that warp's PC and thread mask.
- R3: On a clock edge where `issue_valid` and `issue_ready` are both high, the chosen warp's lockout bit becomes 1. With `issue_ready` low, no lockout bit is set and no PC changes.
- R4: A hand-back (`rel_valid`) with `rel_fetch_stall` = 0 clears the lockout bit of warp `rel_wid` at the next edge. With `rel_fetch_stall` = 1 it has no effect. If the same warp is also accepted for issue on that edge, the hand-back is applied first, so the warp ends up locked out.
- R5: Each accepted issue adds 4 to the issued warp's PC.
- R6: A spawn with count N and entry PC P acts on warps 1 to min(N, NUM_WARPS)-1. Each of these gets PC P, thread mask 1 and its run bit set. Warps at index min(N, NUM_WARPS) and above lose their run bit. Warp 0 keeps its run bit set and its PC unchanged.
- R7: A park request (`bar_suspend`) clears the run bit of warp `bar_suspend_wid`. A parked warp is never chosen until its run bit is set again.
- R8: `issue_count` increases by one on each accepted issue and holds otherwise.
- R9: Each set bit of `bar_activate` sets the run bit of that warp. Within one cycle, a spawn is applied first, then a park, then the wake mask. A spawn wins over a same-cycle PC step of the same warp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | output | 1 | A warp is offered to fetch |
| issue_ready | input | 1 | Fetch accepts the offered warp |
| issue_wid | output | WID_W | Index of offered warp |
| issue_pc | output | 32 | PC of offered warp |
| issue_tmask | output | NUM_THREADS | Thread mask of offered warp |
| rel_valid | input | 1 | Decode hands a warp back |
| rel_wid | input | WID_W | Warp being handed back |
| rel_fetch_stall | input | 1 | Hand-back is for a fetch-stalling instruction (no unlock) |
| spawn_valid | input | 1 | Spawn command |
| spawn_count | input | CNT_W | Requested warp count N |
| spawn_pc | input | 32 | Entry PC for spawned warps |
| bar_suspend | input | 1 | Park one warp |
| bar_suspend_wid | input | WID_W | Warp to park |
| bar_activate | input | NUM_WARPS | Warps to wake |
| active_mask | output | NUM_WARPS | Run bits |
| stalled_mask | output | NUM_WARPS | Lockout bits |
| issue_count | output | COUNT_W | Accepted issue counter |

## Verification
The bench builds the block with NUM_WARPS = 4, NUM_THREADS = 4 and RESET_PC = 0. This makes spawn_count 4 bits wide. A count of 9 therefore exceeds the warp count and exercises the clipping, and a count of 1 deactivates every warp but warp 0. With four warps, the lowest-index choice can be observed while two or three warps compete. The same setting lets a park, a wake and a hand-back coincide on different warps.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
    localparam int PC_W    = 32;
    localparam int PC_STEP = 4;

    typedef logic [PC_W-1:0] pc_t;

    // Mask with one bit set at position idx
    function automatic logic [63:0] bit_at(input int unsigned idx);
        logic [63:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/wsched_pick.sv
module wsched_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Lowest index wins: scan downward so the last hit is the smallest
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/wsched_ctx.sv
module wsched_ctx
    import wsched_pkg::*;
#(
    parameter int  NT       = 4,
    parameter pc_t RESET_PC = '0,
    parameter int  BOOT     = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  pc_t           load_pc,
    input  logic          step,
    output pc_t           pc,
    output logic [NT-1:0] tmask
);
    localparam logic [NT-1:0] THREAD0 = NT'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= (BOOT != 0) ? RESET_PC : '0;
            tmask <= (BOOT != 0) ? THREAD0 : '0;
        end else if (load) begin
            pc    <= load_pc;
            tmask <= THREAD0;
        end else if (step) begin
            pc    <= pc + pc_t'(PC_STEP);
        end
    end
endmodule

// File: rtl/warp_sched.sv
module warp_sched
    import wsched_pkg::*;
#(
    parameter int  NUM_WARPS   = 4,
    parameter int  NUM_THREADS = 4,
    parameter int  COUNT_W     = 32,
    parameter pc_t RESET_PC    = '0,
    localparam int WID_W       = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int CNT_W       = WID_W + 2
) (
    input  logic                   clk,
    input  logic                   rst,
    output logic                   issue_valid,
    input  logic                   issue_ready,
    output logic [WID_W-1:0]       issue_wid,
    output logic [PC_W-1:0]        issue_pc,
    output logic [NUM_THREADS-1:0] issue_tmask,
    input  logic                   rel_valid,
    input  logic [WID_W-1:0]       rel_wid,
    input  logic                   rel_fetch_stall,
    input  logic                   spawn_valid,
    input  logic [CNT_W-1:0]       spawn_count,
    input  logic [PC_W-1:0]        spawn_pc,
    input  logic                   bar_suspend,
    input  logic [WID_W-1:0]       bar_suspend_wid,
    input  logic [NUM_WARPS-1:0]   bar_activate,
    output logic [NUM_WARPS-1:0]   active_mask,
    output logic [NUM_WARPS-1:0]   stalled_mask,
    output logic [COUNT_W-1:0]     issue_count
);
    typedef logic [NUM_WARPS-1:0] wmask_t;

    wmask_t active_q, stalled_q;
    wmask_t ready_set, spawn_sel, step_sel;
    wmask_t unlock, lock, park, run_base;
    logic   pick_found, fire;
    logic [WID_W-1:0] pick_idx;
    pc_t    pc_arr [NUM_WARPS];
    logic [NUM_THREADS-1:0] tm_arr [NUM_WARPS];

    assign ready_set = active_q & ~stalled_q;

    wsched_pick #(.N(NUM_WARPS), .IDX_W(WID_W)) u_pick (
        .req   (ready_set),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign fire = pick_found && issue_ready;

    // Spawn selection: warps 1 .. min(N, NUM_WARPS)-1
    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_sel
        if (g == 0) begin : g_w0
            assign spawn_sel[g] = 1'b0;
        end else begin : g_wn
            assign spawn_sel[g] = spawn_valid && (int'(spawn_count) > g);
        end
        assign step_sel[g] = fire && (pick_idx == WID_W'(g));
    end

    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_ctx
        wsched_ctx #(
            .NT       (NUM_THREADS),
            .RESET_PC (RESET_PC),
            .BOOT     ((g == 0) ? 1 : 0)
        ) u_ctx (
            .clk     (clk),
            .rst     (rst),
            .load    (spawn_sel[g]),
            .load_pc (spawn_pc),
            .step    (step_sel[g]),
            .pc      (pc_arr[g]),
            .tmask   (tm_arr[g])
        );
    end

    // Lockout update: hand-back first, then new lock
    always_comb begin
        unlock = (rel_valid && !rel_fetch_stall) ? wmask_t'(bit_at(rel_wid)) : '0;
        lock   = fire ? wmask_t'(bit_at(pick_idx)) : '0;
    end

    // Run update: spawn, then park, then wake
    always_comb begin
        run_base = spawn_valid ? (spawn_sel | wmask_t'(1)) : active_q;
        park     = bar_suspend ? wmask_t'(bit_at(bar_suspend_wid)) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q    <= wmask_t'(1);
            stalled_q   <= '0;
            issue_count <= '0;
        end else begin
            active_q  <= (run_base & ~park) | bar_activate;
            stalled_q <= (stalled_q & ~unlock) | lock;
            if (fire) begin
                issue_count <= issue_count + COUNT_W'(1);
            end
        end
    end

    assign issue_valid  = pick_found;
    assign issue_wid    = pick_idx;
    assign issue_pc     = pc_arr[pick_idx];
    assign issue_tmask  = tm_arr[pick_idx];
    assign active_mask  = active_q;
    assign stalled_mask = stalled_q;
endmodule

// File: rtl/wsched_chk.sv
module wsched_chk #(
    parameter int NUM_WARPS = 4,
    parameter int WID_W     = 2,
    parameter int COUNT_W   = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 issue_valid,
    input logic                 issue_ready,
    input logic [WID_W-1:0]     issue_wid,
    input logic                 rel_valid,
    input logic [WID_W-1:0]     rel_wid,
    input logic                 rel_fetch_stall,
    input logic                 spawn_valid,
    input logic                 bar_suspend,
    input logic [WID_W-1:0]     bar_suspend_wid,
    input logic [NUM_WARPS-1:0] bar_activate,
    input logic [NUM_WARPS-1:0] active_mask,
    input logic [NUM_WARPS-1:0] stalled_mask,
    input logic [COUNT_W-1:0]   issue_count
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (active_mask == NUM_WARPS'(1)) && (stalled_mask == '0) && (issue_count == '0));

    assert_offer_eligible_R2: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> active_mask[issue_wid] && !stalled_mask[issue_wid]);

    assert_lock_on_accept_R3: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_ready) |=> stalled_mask[$past(issue_wid)]);

    assert_unlock_R4: assert property (@(posedge clk) disable iff (rst)
        (rel_valid && !rel_fetch_stall && !(issue_valid && issue_ready && issue_wid == rel_wid))
        |=> !stalled_mask[$past(rel_wid)]);

    assert_warp0_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (spawn_valid && !(bar_suspend && bar_suspend_wid == '0)) |=> active_mask[0]);

    assert_park_R7: assert property (@(posedge clk) disable iff (rst)
        (bar_suspend && !bar_activate[bar_suspend_wid]) |=> !active_mask[$past(bar_suspend_wid)]);

    assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_ready) |=> issue_count == $past(issue_count) + COUNT_W'(1));

    assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(issue_valid && issue_ready) |=> $stable(issue_count));
endmodule

bind warp_sched wsched_chk #(
    .NUM_WARPS (NUM_WARPS),
    .WID_W     (WID_W),
    .COUNT_W   (COUNT_W)
) u_chk (.*);

// File: tb/sim_warp_sched.sv
`timescale 1ns/1ps
module sim_warp_sched;
    localparam int NW = 4;
    localparam int NT = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue_valid, issue_ready;
    logic [1:0]  issue_wid;
    logic [31:0] issue_pc;
    logic [3:0]  issue_tmask;
    logic        rel_valid;
    logic [1:0]  rel_wid;
    logic        rel_fetch_stall;
    logic        spawn_valid;
    logic [3:0]  spawn_count;
    logic [31:0] spawn_pc;
    logic        bar_suspend;
    logic [1:0]  bar_suspend_wid;
    logic [3:0]  bar_activate;
    logic [3:0]  active_mask, stalled_mask;
    logic [31:0] issue_count;

    always #2.5 clk = ~clk;

    warp_sched #(.NUM_WARPS(NW), .NUM_THREADS(NT)) u0 (.*);

    typedef struct packed {
        logic        rdy;
        logic        rv;
        logic [1:0]  rw;
        logic        rfs;
        logic        sv;
        logic [3:0]  sc;
        logic [31:0] spc;
        logic        pv;
        logic [1:0]  pw;
        logic [3:0]  wake;
        logic        evalid;
        logic [1:0]  ewid;
        logic [31:0] epc;
        logic [3:0]  etm;
        logic [3:0]  eact;
        logic [3:0]  est;
        logic [31:0] ecnt;
    } vec_t;

    // Each row: expected outputs in the current cycle, then inputs for the next edge
    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{0,0,0,0, 0,0,0,          0,0,0, 1,0,32'h0,  1, 1,0,0},  // R3 ready low
        '{1,0,0,0, 0,0,0,          0,0,0, 1,0,32'h0,  1, 1,0,0},  // R3 accept w0
        '{1,1,0,1, 0,0,0,          0,0,0, 0,0,32'h0,  0, 1,1,1},  // R4 fetch-stall hand-back ignored
        '{0,1,0,0, 1,3,32'h100,    0,0,0, 0,0,32'h0,  0, 1,1,1},  // R4 unlock + R6 spawn 3
        '{1,0,0,0, 0,0,0,          0,0,0, 1,0,32'h4,  1, 7,0,1},  // R5 pc+4
        '{1,0,0,0, 0,0,0,          0,0,0, 1,1,32'h100,1, 7,1,2},  // R6 spawned w1
        '{1,1,0,0, 0,0,0,          0,0,0, 1,2,32'h100,1, 7,3,3},  // R2 lowest w2
        '{1,1,0,0, 0,0,0,          0,0,0, 1,0,32'h8,  1, 7,6,4},  // R4 same-warp release-first
        '{0,1,1,0, 0,0,0,          1,1,0, 0,0,32'h0,  0, 7,7,5},  // R7 park w1
        '{0,1,2,0, 0,0,0,          0,0,0, 0,0,32'h0,  0, 5,5,5},  // R7 w1 parked
        '{0,0,0,0, 0,0,0,          1,2,4'b0010, 1,2,32'h104,1, 5,1,5}, // R9 park w2 + wake w1
        '{1,0,0,0, 1,9,32'h200,    0,0,0, 1,1,32'h104,1, 3,1,5},  // R9 spawn over step, clip
        '{1,0,0,0, 0,0,0,          0,0,0, 1,2,32'h200,1, 15,3,6}, // R6 clipped spawn
        '{1,1,1,0, 0,0,0,          0,0,0, 1,3,32'h200,1, 15,7,7}, // R6 w3
        '{0,0,0,0, 1,1,32'h300,    0,0,0, 1,1,32'h200,1, 15,13,8},// R6 spawn 1 ahead
        '{0,1,0,0, 0,0,0,          0,0,0, 0,0,32'h0,  0, 1,13,8}, // R6 only w0 runs
        '{1,0,0,0, 0,0,0,          0,0,0, 1,0,32'hC,  1, 1,12,8}  // R8 final
    };
    localparam string VTAG [NV] = '{
        "R3","R3","R4","R4","R5","R6","R2","R4","R7","R7","R9","R9","R6","R6","R6","R6","R8"
    };

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    int cyc    = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        issue_ready = 0; rel_valid = 0; rel_wid = 0; rel_fetch_stall = 0;
        spawn_valid = 0; spawn_count = 0; spawn_pc = 0;
        bar_suspend = 0; bar_suspend_wid = 0; bar_activate = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic check_reset_state();
        #1;
        chk("R1", "active", 32'(active_mask), 32'h1);
        chk("R1", "stalled", 32'(stalled_mask), 32'h0);
        chk("R1", "count", issue_count, 32'h0);
        chk("R1", "pc", issue_pc, 32'h0);
        chk("R1", "tmask", 32'(issue_tmask), 32'h1);
        chk("R1", "wid", 32'(issue_wid), 32'h0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        do_reset();
        check_reset_state();

        for (int v = 0; v < NV; v++) begin
            // state is checked at negedge+1, inputs drive the next edge
            chk(VTAG[v], "valid", 32'(issue_valid), 32'(TBL[v].evalid));
            if (TBL[v].evalid) begin
                chk(VTAG[v], "wid", 32'(issue_wid), 32'(TBL[v].ewid));
                chk(VTAG[v], "pc", issue_pc, TBL[v].epc);
                chk(VTAG[v], "tmask", 32'(issue_tmask), 32'(TBL[v].etm));
            end
            chk(VTAG[v], "active", 32'(active_mask), 32'(TBL[v].eact));
            chk(VTAG[v], "stalled", 32'(stalled_mask), 32'(TBL[v].est));
            chk(VTAG[v], "count", issue_count, TBL[v].ecnt);
            issue_ready     = TBL[v].rdy;
            rel_valid       = TBL[v].rv;
            rel_wid         = TBL[v].rw;
            rel_fetch_stall = TBL[v].rfs;
            spawn_valid     = TBL[v].sv;
            spawn_count     = TBL[v].sc;
            spawn_pc        = TBL[v].spc;
            bar_suspend     = TBL[v].pv;
            bar_suspend_wid = TBL[v].pw;
            bar_activate    = TBL[v].wake;
            @(negedge clk);
            idle_inputs();
            #1;
        end

        // Directed: reset in the middle of activity restores R1
        do_reset();
        check_reset_state();

        // Directed: spawn count 0 leaves only warp 0 (R6)
        @(negedge clk);
        spawn_valid = 1; spawn_count = 0; spawn_pc = 32'h40;
        @(negedge clk);
        idle_inputs();
        #1;
        chk("R6", "active after count 0", 32'(active_mask), 32'h1);

        // Directed: spawn count 2 wakes warp 1 only, entry PC and thread 0 (R6)
        spawn_valid = 1; spawn_count = 2; spawn_pc = 32'h40;
        @(negedge clk);
        idle_inputs();
        #1;
        chk("R6", "active after count 2", 32'(active_mask), 32'h3);
        issue_ready = 1;
        @(negedge clk);
        #1;
        chk("R2", "second pick wid", 32'(issue_wid), 32'h1);
        chk("R6", "warp1 pc", issue_pc, 32'h40);
        chk("R6", "warp1 tmask", 32'(issue_tmask), 32'h1);
        @(negedge clk);
        idle_inputs();
        #1;
        chk("R3", "both locked", 32'(stalled_mask), 32'h3);
        chk("R8", "count after two", issue_count, 32'h2);
        chk("R2", "none eligible", 32'(issue_valid), 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule